// File: doc/BRIEF.md
# Serial Port Sticky Status Flags

This block keeps two sticky status flags for a serial port and puts them behind a small register read/write port. The first flag, the transmit-stop flag, rises when a running count of transmitted characters reaches a threshold that software programs. The second flag, the receive-error flag, rises when the receiver reports a framing error or a parity error while it is enabled. The block contains the character counter, the threshold register, the comparator and the flag logic. The serial shifter, the baud generator and the FIFOs sit elsewhere.

Software clears a flag with a handshake. It first reads the status register and sees the flag as 1. It then writes 0 to that flag's bit. A write of 0 that has no such read before it leaves the flag set, and so does a write of 1. When the receiver is disabled, the error flag holds whatever value it had. An asynchronous power-on reset and a synchronous manual reset each return the block to its reset state.

Top module: `serial_flag_regs`

## Requirements
- R1: After the power-on reset or the manual reset, both flags read 0, the character counter is 0, neither flag is armed for clearing and the threshold reads 0.
- R2: Each cycle with `txCharDone` high adds one to the character counter, which wraps modulo 2^CNT_W. `txStop` is set at the clock edge where the counter's new value equals the threshold. With a threshold of 0, the flag sets on character number 2^CNT_W.
- R3: `rxErr` is set at the clock edge after a cycle in which `rxEnable` is high and `rxFrameErr` or `rxParityErr` is high.
- R4: A flag clears on a status write whose bit for that flag is 0, but only if a status read returned that flag as 1 after the last status write. A status read that returns the flag as 0 does not arm the clear.
- R5: Writing 1 to a flag bit leaves that flag unchanged. Clearing one flag leaves the other flag unchanged.
- R6: When a set event and a qualified clearing write fall in the same cycle, the flag ends up set.
- R7: While `rxEnable` is low, `rxErr` keeps its value and error reports are ignored.
- R8: With `regSel` = 0, `rdData` shows the status word: bit 0 is `txStop`, bit 1 is `rxErr` and all higher bits are 0. With `regSel` = 1, `rdData` shows the threshold, and a write with `regSel` = 1 loads `wrData` into the threshold.
- R9: A manual reset pulse clears the flags, the threshold and the counter, so that counting starts again from zero.
- R10: Every status write, whatever its data, disarms both flags. A second clear needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| manRst | input | 1 | Synchronous manual reset, active high |
| regSel | input | 1 | Register select: 0 = status, 1 = threshold |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; a status read arms the flags that read 1 |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data of the selected register |
| txCharDone | input | 1 | One-cycle pulse for each character that finishes transmitting |
| rxEnable | input | 1 | Receiver enable |
| rxFrameErr | input | 1 | Framing error report from the receiver |
| rxParityErr | input | 1 | Parity error report from the receiver |

## Verification
The assertions assume that `regRd` and `regWr` are never high in the same cycle. They also assume that every input is a known value at each clock edge, because the arm and clear properties reason about read and write as separate events. The stimulus drives each register access from its own task, so a read and a write never share a cycle. It changes inputs only on the falling edge. The cases that combine an event with a clearing write put the event pulse next to a single write and never next to a read.

// File: rtl/serial_flag_pkg.sv
package serial_flag_pkg;
  localparam int TX_BIT = 0;
  localparam int RX_BIT = 1;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_THRESH = 1'b1
  } regSel_e;

  typedef struct packed {
    logic clrTx;
    logic clrRx;
    logic ldThr;
  } flagStrobe_t;
endpackage

// File: rtl/serial_flag_ctrl.sv
module serial_flag_ctrl
  import serial_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRst,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              txStop,
  input  logic              rxErr,
  output flagStrobe_t       strobe
);
  logic [1:0] arm, armNext;
  logic statWr, statRd;

  assign statWr = regWr && (regSel == SEL_STATUS);
  assign statRd = regRd && (regSel == SEL_STATUS);

  always_comb begin
    strobe.clrTx = statWr && !wrData[TX_BIT] && arm[TX_BIT];
    strobe.clrRx = statWr && !wrData[RX_BIT] && arm[RX_BIT];
    strobe.ldThr = regWr && (regSel == SEL_THRESH);
  end

  // Any status write disarms both flags; a status read arms the flags that read 1.
  always_comb begin
    armNext = statWr ? 2'b00 : arm;
    if (statRd) begin
      armNext[TX_BIT] = armNext[TX_BIT] | txStop;
      armNext[RX_BIT] = armNext[RX_BIT] | rxErr;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)    arm <= 2'b00;
    else if (manRst) arm <= 2'b00;
    else             arm <= armNext;
  end

  // R4: an armed flag is always a flag that is still set
  a_r4_arm_implies_tx: assert property (@(posedge clk) disable iff (!porRstN)
    arm[TX_BIT] |-> txStop);
  a_r4_arm_implies_rx: assert property (@(posedge clk) disable iff (!porRstN)
    arm[RX_BIT] |-> rxErr);
  // R10: a status write without a read leaves nothing armed
  a_r10_write_disarms: assert property (@(posedge clk) disable iff (!porRstN)
    (statWr && !regRd) |=> (arm == 2'b00));
endmodule

// File: rtl/serial_flag_dp.sv
module serial_flag_dp
  import serial_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRst,
  input  flagStrobe_t       strobe,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              txCharDone,
  input  logic              rxEnable,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  output logic              txStop,
  output logic              rxErr,
  output logic [CNT_W-1:0]  thresh
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] txCount, countNext;
  logic txHit, rxHit;

  assign countNext = txCount + ONE;
  assign txHit     = txCharDone && (countNext == thresh);
  assign rxHit     = rxEnable && (rxFrameErr || rxParityErr);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      txCount <= '0;
      thresh  <= '0;
      txStop  <= 1'b0;
      rxErr   <= 1'b0;
    end else if (manRst) begin
      txCount <= '0;
      thresh  <= '0;
      txStop  <= 1'b0;
      rxErr   <= 1'b0;
    end else begin
      if (txCharDone)   txCount <= countNext;
      if (strobe.ldThr) thresh  <= wrData;
      // set wins over a same-cycle clear
      txStop <= txHit | (txStop & ~strobe.clrTx);
      rxErr  <= rxHit | (rxErr  & ~strobe.clrRx);
    end
  end

  // R2: the counter steps by one per finished character
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!porRstN || manRst)
    txCharDone |=> (txCount == $past(txCount) + ONE));
  // R3: an enabled error report always leaves the flag set
  a_r3_rx_sets: assert property (@(posedge clk) disable iff (!porRstN || manRst)
    (rxEnable && (rxFrameErr || rxParityErr)) |=> rxErr);
  // R7: with the receiver off and no clear, the error flag holds
  a_r7_rx_holds: assert property (@(posedge clk) disable iff (!porRstN || manRst)
    (!rxEnable && !strobe.clrRx) |=> $stable(rxErr));
  // R4: a flag drops only after a qualified clear or a manual reset
  a_r4_tx_fall_cause: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(txStop) |-> ($past(strobe.clrTx) || $past(manRst)));
  a_r4_rx_fall_cause: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(rxErr) |-> ($past(strobe.clrRx) || $past(manRst)));
endmodule

// File: rtl/serial_flag_regs.sv
module serial_flag_regs
  import serial_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRst,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              txCharDone,
  input  logic              rxEnable,
  input  logic              rxFrameErr,
  input  logic              rxParityErr
);
  flagStrobe_t strobe;
  logic txStop, rxErr;
  logic [CNT_W-1:0] thresh;

  serial_flag_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .manRst(manRst),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .txStop(txStop), .rxErr(rxErr), .strobe(strobe)
  );

  serial_flag_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .manRst(manRst),
    .strobe(strobe), .wrData(wrData),
    .txCharDone(txCharDone), .rxEnable(rxEnable),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .txStop(txStop), .rxErr(rxErr), .thresh(thresh)
  );

  assign rdData = (regSel == SEL_THRESH) ? thresh
                                         : {{(CNT_W-2){1'b0}}, rxErr, txStop};

  // R8: the status word never carries bits above the two flags
  a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!porRstN)
    (regSel == SEL_STATUS) |-> (rdData[CNT_W-1:2] == '0));
endmodule

// File: tb/serial_flag_regs_tb.sv
`timescale 1ns/1ps
module serial_flag_regs_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic porRstN = 1'b0, manRst = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic txCharDone = 1'b0, rxEnable = 1'b0, rxFrameErr = 1'b0, rxParityErr = 1'b0;

  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  serial_flag_regs #(.CNT_W(W)) u_dut (
    .clk(clk), .porRstN(porRstN), .manRst(manRst),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .txCharDone(txCharDone), .rxEnable(rxEnable),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr)
  );

  task automatic chk(input string req, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wrReg(input logic sel, input logic [W-1:0] d);
    regSel = sel; wrData = d; regWr = 1'b1; tick(); regWr = 1'b0; regSel = 1'b0;
  endtask

  task automatic rdStatus();
    regSel = 1'b0; regRd = 1'b1; tick(); regRd = 1'b0;
  endtask

  function automatic int peekStatus(); return int'(rdData); endfunction

  task automatic peekThresh(output int v);
    regSel = 1'b1; #1 v = int'(rdData); regSel = 1'b0; #0;
  endtask

  task automatic chars(input int n);
    for (int i = 0; i < n; i++) begin txCharDone = 1'b1; tick(); end
    txCharDone = 1'b0;
  endtask

  task automatic doReset(); manRst = 1'b1; tick(); manRst = 1'b0; endtask

  task automatic setFlag(input int f);
    if (f == 0) begin wrReg(1'b1, W'(1)); chars(1); end
    else begin rxEnable = 1'b1; rxFrameErr = 1'b1; tick(); rxFrameErr = 1'b0; end
  endtask

  initial begin
    int v;
    tick(); tick();
    // R1: power-on reset state
    chk("R1 status at power-on", peekStatus(), 0);
    peekThresh(v); chk("R1 threshold at power-on", v, 0);
    porRstN = 1'b1; tick();
    chk("R1 status after release", peekStatus(), 0);

    // R2/R8: sweep every threshold against every character count
    for (int thr = 0; thr < (1 << W); thr++) begin
      doReset();
      wrReg(1'b1, W'(thr));
      peekThresh(v); chk("R8 threshold readback", v, thr);
      for (int k = 1; k <= (1 << W) + 1; k++) begin
        int eff;
        eff = (thr == 0) ? (1 << W) : thr;
        chars(1);
        chk("R2 txStop after chars", peekStatus(), (k >= eff) ? 1 : 0);
      end
    end

    // R3/R7: every combination of enable and error inputs from a clean state
    for (int c = 0; c < 8; c++) begin
      doReset();
      rxEnable = c[0]; rxFrameErr = c[1]; rxParityErr = c[2];
      tick();
      rxFrameErr = 1'b0; rxParityErr = 1'b0;
      chk(c[0] ? "R3 error report" : "R7 report while disabled",
          peekStatus(), (c[0] && (c[1] || c[2])) ? 2 : 0);
    end
    // R7: disabling the receiver holds a set flag
    doReset(); setFlag(1);
    rxEnable = 1'b0; tick(); tick();
    chk("R7 flag held after disable", peekStatus(), 2);
    rxFrameErr = 1'b1; rxParityErr = 1'b1; tick(); rxFrameErr = 1'b0; rxParityErr = 1'b0;
    chk("R7 flag held with reports while off", peekStatus(), 2);

    // R4/R5: clear handshake sweep per flag, prior read, written bit
    for (int f = 0; f < 2; f++)
      for (int rd = 0; rd < 2; rd++)
        for (int wb = 0; wb < 2; wb++) begin
          doReset(); setFlag(f);
          if (rd == 1) rdStatus();
          wrReg(1'b0, (wb == 1) ? W'(1 << f) : W'(0));
          chk((wb == 1) ? "R5 write one ignored" : "R4 clear handshake",
              peekStatus(), (rd == 1 && wb == 0) ? 0 : (1 << f));
        end
    // R4: a read that saw 0 does not arm
    doReset(); rdStatus(); setFlag(1); wrReg(1'b0, '0);
    chk("R4 read of zero does not arm", peekStatus(), 2);
    // R5: clearing one flag spares the other
    doReset(); setFlag(0); setFlag(1); rdStatus(); wrReg(1'b0, W'(2));
    chk("R5 tx cleared, rx kept", peekStatus(), 2);
    // R10: a write of one disarms; the following zero needs a new read
    doReset(); setFlag(0); rdStatus(); wrReg(1'b0, W'(1)); wrReg(1'b0, '0);
    chk("R10 disarmed by write", peekStatus(), 1);
    rdStatus(); wrReg(1'b0, '0);
    chk("R10 cleared after new read", peekStatus(), 0);

    // R6: set wins over a same-cycle clear
    doReset(); setFlag(0); wrReg(1'b1, W'(2)); rdStatus();
    txCharDone = 1'b1; wrReg(1'b0, '0); txCharDone = 1'b0;
    chk("R6 tx set wins", peekStatus(), 1);
    doReset(); setFlag(1); rdStatus();
    rxFrameErr = 1'b1; wrReg(1'b0, '0); rxFrameErr = 1'b0;
    chk("R6 rx set wins", peekStatus(), 2);

    // R9: manual reset clears flags, threshold and counter
    doReset(); wrReg(1'b1, W'(5)); setFlag(1); chars(5);
    chk("R9 both set before reset", peekStatus(), 3);
    doReset();
    chk("R9 flags after manual reset", peekStatus(), 0);
    peekThresh(v); chk("R9 threshold after manual reset", v, 0);
    wrReg(1'b1, W'(3)); chars(2);
    chk("R9 counter restarted (2 chars)", peekStatus(), 0);
    chars(1);
    chk("R9 counter restarted (3 chars)", peekStatus(), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule